// File: doc/BRIEF.md
# Word Serializer with Wrap Loopback

This block is the transmit half of a 10-bit serial link. A parallel character is captured on each rising edge of a word clock. It is then shifted out one bit per bit tick, least significant bit first. The bit rate is ten times the word rate. Words follow one another with no idle bit between them, as long as the word clock keeps pace. If no word is waiting when a character finishes, the serial stream drops to low until the next capture.

The serial domain is modelled as a fast core clock `clk_i` with a one-cycle enable `bit_tick_i`. The word clock `word_clk_i` is a level that is sampled in that domain, and its rising edge acts as the capture strobe. A wrap control selects what reaches the outputs. In normal mode the stream drives a complementary line pair. In wrap mode the line pair is pinned high and the stream is diverted to a loopback output that feeds the local receiver. Switching wrap does not disturb the shifting, so the stream continues from the same bit position.

Top module: `word_serializer`

## Requirements
- R1: `word_i` is captured on the core clock edge at which `word_clk_i` is high and was low on the previous edge. A change on `word_i` at any other edge has no effect on the stream.
- R2: Bit 0 of a captured word is shifted out first and bit 9 last. One bit is presented per `bit_tick_i` edge, and the first bit appears after the first tick that follows the capture while the shifter is idle.
- R3: If the next word has been captured by the time bit 9 of the current word is showing, its bit 0 appears on the very next tick, with no gap.
- R4: If no word is waiting when bit 9 ends, the stream goes low on the next tick and stays low until a word is loaded.
- R5: The outputs do not change on core clock edges where `bit_tick_i` is low, unless `wrap_i` changes.
- R6: After reset, the stream is low, so `line_p_o` and `loop_o` are low (wrap off) until the first word has been captured and loaded.
- R7: While `wrap_i` is 1, `line_p_o` is 1 and `line_n_o` is 0, whatever the data.
- R8: While `wrap_i` is 1, `loop_o` carries the serial stream. While `wrap_i` is 0, `loop_o` is 0 and `line_p_o` carries the stream.
- R9: `line_n_o` is always the logical inverse of `line_p_o`.
- R10: Changing `wrap_i` in the middle of a word does not alter the bit sequence. The remaining bits continue on whichever output is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock of the serial domain |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle enable marking each serial bit time |
| word_clk_i | input | 1 | Word clock level; its rising edge captures a word |
| word_i | input | 10 | Parallel character, bit 0 sent first |
| wrap_i | input | 1 | 1 selects internal loopback, 0 normal line operation |
| line_p_o | output | 1 | Line output, true side |
| line_n_o | output | 1 | Line output, complement side |
| loop_o | output | 1 | Serial stream toward the receiver during wrap |

## Verification
A word raised on the word clock together with tick k is captured at that edge. Its bit j is shown after tick k+1+j, so the first bit is due one tick after capture and later words follow every ten ticks. The driver pushes one expected bit for each tick into a queue, with a single leading idle zero to cover that latency. The monitor pops exactly one entry on the falling clock edge after each tick and compares it there. It also re-checks on the next falling edge, where no tick has occurred, that the output has held. The wrap mapping is combinational, so the monitor applies the wrap value of that same tick when it forms the expected line and loopback levels.

// File: rtl/word_ser_pkg.sv
package word_ser_pkg;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_e;

endpackage

// File: rtl/word_capture.sv
module word_capture #(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_clk_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              full_o
);

  logic              word_clk_q;
  logic              rise;
  logic [WORD_W-1:0] hold_q;
  logic              full_q;

  assign rise = word_clk_i & ~word_clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_clk_q <= 1'b0;
      hold_q     <= '0;
      full_q     <= 1'b0;
    end else begin
      word_clk_q <= word_clk_i;
      if (rise) hold_q <= word_i;
      // a capture in the same cycle as a take refills the holding slot
      if (rise)        full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
  assign full_o = full_q;

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter
  import word_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] hold_i,
  output logic              take_o,
  output logic              serial_o
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  sh_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sreg_q;
  logic              last;

  assign last   = (state_q == SH_IDLE) || (cnt_q == LAST_IDX);
  assign take_o = tick_i & last & full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      sreg_q  <= '0;
    end else if (tick_i) begin
      if (last) begin
        cnt_q <= '0;
        if (full_i) begin
          sreg_q  <= hold_i;
          state_q <= SH_RUN;
        end else begin
          sreg_q  <= '0;
          state_q <= SH_IDLE;
        end
      end else begin
        sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign serial_o = sreg_q[0];

endmodule

// File: rtl/wrap_mux.sv
module wrap_mux (
  input  logic wrap_i,
  input  logic serial_i,
  output logic line_p_o,
  output logic line_n_o,
  output logic loop_o
);

  logic line_val;

  always_comb begin
    line_val = wrap_i ? 1'b1 : serial_i;
    loop_o   = wrap_i ? serial_i : 1'b0;
  end

  assign line_p_o = line_val;
  assign line_n_o = ~line_val;

endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              word_clk_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wrap_i,
  output logic              line_p_o,
  output logic              line_n_o,
  output logic              loop_o
);

  logic [WORD_W-1:0] hold;
  logic              full;
  logic              take;
  logic              serial_bit;

  word_capture #(.WORD_W(WORD_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_clk_i (word_clk_i),
    .word_i     (word_i),
    .take_i     (take),
    .hold_o     (hold),
    .full_o     (full)
  );

  bit_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (bit_tick_i),
    .full_i   (full),
    .hold_i   (hold),
    .take_o   (take),
    .serial_o (serial_bit)
  );

  wrap_mux u_mux (
    .wrap_i   (wrap_i),
    .serial_i (serial_bit),
    .line_p_o (line_p_o),
    .line_n_o (line_n_o),
    .loop_o   (loop_o)
  );

endmodule

// File: rtl/word_serializer_chk.sv
module word_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic word_clk_i,
  input logic wrap_i,
  input logic line_p_o,
  input logic line_n_o,
  input logic loop_o,
  input logic serial_bit
);

  logic wclk_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      wclk_q <= word_clk_i;
      if (word_clk_i && !wclk_q) seen_q <= 1'b1;
    end
  end

  p_compl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_n_o == !line_p_o);

  p_wrap_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> (line_p_o && !line_n_o));

  p_loop_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> (loop_o == serial_bit));

  p_line_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |-> (!loop_o && (line_p_o == serial_bit)));

  p_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!serial_bit && !loop_o && (wrap_i || !line_p_o)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> ((wrap_i != $past(wrap_i)) || $stable(line_p_o)));

endmodule

bind word_serializer word_serializer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .word_clk_i (word_clk_i),
  .wrap_i     (wrap_i),
  .line_p_o   (line_p_o),
  .line_n_o   (line_n_o),
  .loop_o     (loop_o),
  .serial_bit (serial_bit)
);

// File: tb/word_serializer_tb.sv
`timescale 1ns/1ps
module word_serializer_tb;

  localparam int W = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bit_tick_i = 1'b0;
  logic         word_clk_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         wrap_i = 1'b0;
  logic         line_p_o, line_n_o, loop_o;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  exp_q[$];

  always #10 clk_i = ~clk_i;

  word_serializer #(.WORD_W(W)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .word_clk_i (word_clk_i),
    .word_i     (word_i),
    .wrap_i     (wrap_i),
    .line_p_o   (line_p_o),
    .line_n_o   (line_n_o),
    .loop_o     (loop_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one tick: three core cycles, tick high for the first posedge
  task automatic one_tick(input bit raise, input bit lower, input logic [W-1:0] w,
                          input logic wrap);
    @(negedge clk_i);
    bit_tick_i = 1'b1;
    wrap_i     = wrap;
    if (raise) begin
      word_clk_i = 1'b1;
      word_i     = w;
    end else begin
      if (lower) word_clk_i = 1'b0;
      word_i = $urandom;  // R1: noise away from the capture edge
    end
    @(negedge clk_i);
    bit_tick_i = 1'b0;
    @(negedge clk_i);
  endtask

  // wrap_mode: 0 off, 1 on, 2 toggles mid-word, 3 random per tick
  task automatic run_slot(input bit has_word, input logic [W-1:0] w, input int wrap_mode);
    for (int j = 0; j < W; j++) exp_q.push_back(has_word ? w[j] : 1'b0);
    for (int k = 0; k < W; k++) begin
      logic wv;
      case (wrap_mode)
        0: wv = 1'b0;
        1: wv = 1'b1;
        2: wv = (k >= 4);
        default: wv = 1'(($urandom % 2));
      endcase
      one_tick(has_word && k == 0, k == 5, w, wv);
    end
  endtask

  // monitor: one expected bit per tick, checked after the tick edge
  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni && bit_tick_i) begin
        bit   e;
        logic held;
        @(negedge clk_i);
        if (exp_q.size() == 0) begin
          check("R3 queue underflow", 1'b1, 1'b0);
          e = 1'b0;
        end else begin
          e = exp_q.pop_front();
        end
        if (wrap_i) begin
          check("R7 line pinned high", line_p_o, 1'b1);
          check("R8/R10 loop stream", loop_o, e);
        end else begin
          check("R2/R3/R4 line stream", line_p_o, e);
          check("R8 loop quiet", loop_o, 1'b0);
        end
        check("R9 complement", line_n_o, ~line_p_o);
        held = line_p_o;
        @(negedge clk_i);
        check("R5 hold between ticks", line_p_o, held);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R6 reset line low", line_p_o, 1'b0);
    check("R6 reset loop low", loop_o, 1'b0);
    check("R9 reset complement", line_n_o, 1'b1);
    rst_ni = 1'b1;
    exp_q.push_back(1'b0);  // leading idle bit: first load is one tick after capture
    run_slot(1'b0, '0, 0);            // R6 idle before any word
    run_slot(1'b1, 10'h2AA, 0);       // R2 alternating
    run_slot(1'b1, 10'h155, 0);       // R3 back to back
    run_slot(1'b1, 10'h001, 0);       // R2 bit 0 first
    run_slot(1'b1, 10'h200, 0);       // R2 bit 9 last
    run_slot(1'b0, '0, 0);            // R4 gap returns low
    run_slot(1'b1, 10'h3E7, 1);       // R7/R8 wrap whole word
    run_slot(1'b1, 10'h0F3, 2);       // R10 wrap switched mid-word
    run_slot(1'b1, 10'h3FF, 0);       // R3 all ones
    for (int s = 0; s < 24; s++) begin
      bit has = (($urandom % 5) != 0);
      run_slot(has, W'($urandom), 3);
    end
    run_slot(1'b0, '0, 0);
    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule